// File: doc/BRIEF.md
# Machine-Check Error Record Classifier

This block walks the status words of a set of error-reporting banks during a scan. For each owned bank it decides one of three outcomes. The record is logged, it is forwarded to an action pool for follow-up only, or it is skipped. A scan begins on a start pulse and examines one bank per clock cycle, in ascending bank index order. Banks outside the owned mask take up their cycle but produce no outcome.

Each bank supplies a five-bit status word with these fields: bit 0 is valid, bit 1 is uncorrected, bit 2 is context-corrupt, bit 3 is signalling, and bit 4 is address-usable.

The mode flags are latched together with the owned mask when the scan starts. They select three things: whether the running time counter is captured into each outcome, whether uncorrected records are accepted unconditionally, and whether logging is withheld. A separate global flag withholds logging of accepted records in the same way as the don't-log mode.

Top module: `mca_err_classify`

## Requirements
- R1: After reset, rec_log, rec_fwd, rec_skip and scan_done are all low.
- R2: A start pulse accepted while idle examines bank i in the cycle i+1 edges after the start edge, in ascending order. Only banks whose bit is set in the owned mask raise an outcome strobe. rec_bank and rec_status (bit 0 valid, bit 1 uncorrected, bit 2 context-corrupt, bit 3 signalling, bit 4 address-usable) carry the examined bank.
- R3: A record with bit 0 (valid) clear is skipped.
- R4: A valid record with bit 1 (uncorrected) clear is accepted, and it is logged when neither withholding flag is set.
- R5: With the log-all mode set, a valid uncorrected record is accepted whatever its other bits are.
- R6: A valid uncorrected record whose bits 2 and 3 are both clear is accepted as uncorrected-no-action.
- R7: A valid uncorrected record with bit 2 or bit 3 set is skipped when log-all is clear.
- R8: When don't-log or the global suppress flag is set, an accepted record is forwarded if bit 4 (address-usable) is set, and skipped otherwise.
- R9: With the timestamp mode set, rec_tsc carries now_tsc as sampled at the examining edge and rec_tsc_vld is high. With the mode clear, rec_tsc_vld is low and rec_tsc is zero.
- R10: Exactly one of rec_log, rec_fwd and rec_skip is high for each owned bank examined, and none is high at any other time.
- R11: scan_done pulses for exactly one cycle, in the cycle that carries the last bank. A start pulse during a scan is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Start pulse for a scan |
| owned_mask | input | NBANK | Banks to examine, latched at start |
| mode_tstamp | input | 1 | Capture time counter, latched at start |
| mode_log_all | input | 1 | Accept every uncorrected record, latched at start |
| mode_no_log | input | 1 | Withhold logging, latched at start |
| ce_suppress | input | 1 | Global withhold of logging, latched at start |
| bank_status | input | NBANK*5 | Status word of every bank, 5 bits per bank |
| now_tsc | input | TSW | Running time counter |
| rec_log | output | 1 | Log strobe |
| rec_fwd | output | 1 | Forward-to-pool strobe |
| rec_skip | output | 1 | Skip indication |
| rec_bank | output | IW | Index of the examined bank |
| rec_status | output | 5 | Status word of the examined bank |
| rec_tsc_vld | output | 1 | rec_tsc holds a captured time |
| rec_tsc | output | TSW | Captured time counter |
| scan_done | output | 1 | One-cycle pulse with the last bank |

## Verification
The results for bank i are registered at the (i+1)th rising edge after the edge that accepts the start. scan_done is registered at the NBANK-th edge. The bench drives start on a falling edge and releases it on the next falling edge. It then samples once per falling edge, so the k-th sample after release holds bank k-1 and the NBANK-th sample also holds scan_done. One further sample checks that the outputs have gone quiet. This also shows that a start pulse given during the scan did not launch a second scan.

// File: rtl/mca_cls_pkg.sv
package mca_cls_pkg;
    // Status word layout, bit 0 is the least significant field.
    typedef struct packed {
        logic addrv;   // bit 4
        logic sig;     // bit 3
        logic pcc;     // bit 2
        logic uc;      // bit 1
        logic val;     // bit 0
    } bank_stat_t;

    localparam int STW = $bits(bank_stat_t);

    typedef enum logic [1:0] {
        ACT_SKIP = 2'd0,
        ACT_LOG  = 2'd1,
        ACT_FWD  = 2'd2
    } cls_act_e;
endpackage

// File: rtl/mca_cls_decide.sv
module mca_cls_decide
    import mca_cls_pkg::*;
(
    input  bank_stat_t st,
    input  logic       log_all,
    input  logic       no_log,
    input  logic       suppress,
    output cls_act_e   act
);
    logic accepted;
    logic ucna;
    logic withheld;

    always_comb begin
        ucna     = st.uc && !st.pcc && !st.sig;
        accepted = st.val && (log_all || !st.uc || ucna);
        withheld = no_log || suppress;
        if (!accepted) begin
            act = ACT_SKIP;
        end else if (!withheld) begin
            act = ACT_LOG;
        end else if (st.addrv) begin
            act = ACT_FWD;
        end else begin
            act = ACT_SKIP;
        end
    end
endmodule

// File: rtl/mca_cls_scan.sv
module mca_cls_scan #(
    parameter int NBANK = 8,
    localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          take,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBANK - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
    } scan_st_t;

    scan_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        take = start && !s_q.busy;
        last = s_q.busy && (s_q.idx == LAST_IDX);
        if (take) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
        end else if (s_q.busy) begin
            if (last) begin
                s_d.busy = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign idx  = s_q.idx;

    // R11: a running scan is never restarted from the middle
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !last) |=> (s_q.busy && s_q.idx == $past(s_q.idx) + 1'b1));
endmodule

// File: rtl/mca_err_classify.sv
module mca_err_classify
    import mca_cls_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int TSW   = 32,
    localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_start,
    input  logic [NBANK-1:0]   owned_mask,
    input  logic               mode_tstamp,
    input  logic               mode_log_all,
    input  logic               mode_no_log,
    input  logic               ce_suppress,
    input  logic [NBANK*5-1:0] bank_status,
    input  logic [TSW-1:0]     now_tsc,
    output logic               rec_log,
    output logic               rec_fwd,
    output logic               rec_skip,
    output logic [IW-1:0]      rec_bank,
    output logic [4:0]         rec_status,
    output logic               rec_tsc_vld,
    output logic [TSW-1:0]     rec_tsc,
    output logic               scan_done
);
    typedef struct packed {
        logic [NBANK-1:0] mask;
        logic             ts;
        logic             la;
        logic             nl;
        logic             sp;
    } cfg_t;

    typedef struct packed {
        logic           log_s;
        logic           fwd_s;
        logic           skip_s;
        logic [IW-1:0]  bank;
        bank_stat_t     stat;
        logic           tsv;
        logic [TSW-1:0] tsc;
        logic           done;
    } out_t;

    cfg_t cfg_d, cfg_q;
    out_t o_d, o_q;

    logic          take, busy, last;
    logic [IW-1:0] idx;
    bank_stat_t    cur_st;
    cls_act_e      act;
    bank_stat_t    st_arr [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_unpack
        assign st_arr[g] = bank_stat_t'(bank_status[g*STW +: STW]);
    end

    assign cur_st = st_arr[idx];

    mca_cls_scan #(.NBANK(NBANK)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .start (scan_start),
        .take  (take),
        .busy  (busy),
        .idx   (idx),
        .last  (last)
    );

    mca_cls_decide u_decide (
        .st       (cur_st),
        .log_all  (cfg_q.la),
        .no_log   (cfg_q.nl),
        .suppress (cfg_q.sp),
        .act      (act)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (take) begin
            cfg_d.mask = owned_mask;
            cfg_d.ts   = mode_tstamp;
            cfg_d.la   = mode_log_all;
            cfg_d.nl   = mode_no_log;
            cfg_d.sp   = ce_suppress;
        end

        o_d      = '0;
        o_d.done = last;
        if (busy && cfg_q.mask[idx]) begin
            o_d.log_s  = (act == ACT_LOG);
            o_d.fwd_s  = (act == ACT_FWD);
            o_d.skip_s = (act == ACT_SKIP);
            o_d.bank   = idx;
            o_d.stat   = cur_st;
            o_d.tsv    = cfg_q.ts;
            o_d.tsc    = cfg_q.ts ? now_tsc : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            o_q   <= '0;
        end else begin
            cfg_q <= cfg_d;
            o_q   <= o_d;
        end
    end

    assign rec_log     = o_q.log_s;
    assign rec_fwd     = o_q.fwd_s;
    assign rec_skip    = o_q.skip_s;
    assign rec_bank    = o_q.bank;
    assign rec_status  = o_q.stat;
    assign rec_tsc_vld = o_q.tsv;
    assign rec_tsc     = o_q.tsc;
    assign scan_done   = o_q.done;

    // R10: at most one outcome strobe per cycle
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_log, rec_fwd, rec_skip}));
    // R10: an owned bank under examination always yields an outcome
    a_r10_owned_out: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.mask[idx]) |=> ($countones({rec_log, rec_fwd, rec_skip}) == 1));
    // R3: only valid records are logged or forwarded
    a_r3_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_log || rec_fwd) |-> rec_status[0]);
    // R8: forwarding needs a usable address
    a_r8_fwd_addr: assert property (@(posedge clk) disable iff (!rst_n)
        rec_fwd |-> rec_status[4]);
    // R9: no time value without the capture mode
    a_r9_tsc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_tsc_vld |-> (rec_tsc == '0));
    // R11: done lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);
endmodule

// File: tb/sim_mca_err_classify.sv
module sim_mca_err_classify;
    localparam int NB  = 8;
    localparam int TSW = 32;
    localparam int IW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scan_start = 1'b0;
    logic [NB-1:0]   owned_mask = '0;
    logic            mode_tstamp = 1'b0, mode_log_all = 1'b0, mode_no_log = 1'b0, ce_suppress = 1'b0;
    logic [NB*5-1:0] bank_status = '0;
    logic [TSW-1:0]  now_tsc = '0;
    logic            rec_log, rec_fwd, rec_skip, rec_tsc_vld, scan_done;
    logic [IW-1:0]   rec_bank;
    logic [4:0]      rec_status;
    logic [TSW-1:0]  rec_tsc;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] st [NB];

    always #2 clk = ~clk;

    mca_err_classify #(.NBANK(NB), .TSW(TSW)) u0 (
        .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .owned_mask(owned_mask),
        .mode_tstamp(mode_tstamp), .mode_log_all(mode_log_all), .mode_no_log(mode_no_log),
        .ce_suppress(ce_suppress), .bank_status(bank_status), .now_tsc(now_tsc),
        .rec_log(rec_log), .rec_fwd(rec_fwd), .rec_skip(rec_skip), .rec_bank(rec_bank),
        .rec_status(rec_status), .rec_tsc_vld(rec_tsc_vld), .rec_tsc(rec_tsc),
        .scan_done(scan_done)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected outcome {log,fwd,skip} and the requirement that decides it
    function automatic logic [2:0] exp_out(logic [4:0] s, logic la, logic nl, logic sp, output string tag);
        logic acc;
        acc = s[0] && (la || !s[1] || (!s[2] && !s[3]));
        if (!s[0]) tag = "R3";
        else if (s[1] && !la && (s[2] || s[3])) tag = "R7";
        else if (nl || sp) tag = "R8";
        else if (s[1] && la) tag = "R5";
        else if (s[1]) tag = "R6";
        else tag = "R4";
        if (!acc) return 3'b001;
        if (!(nl || sp)) return 3'b100;
        return s[4] ? 3'b010 : 3'b001;
    endfunction

    task automatic run_scan(logic [NB-1:0] mask, logic ts, logic la, logic nl, logic sp,
                            logic [TSW-1:0] tsc, logic poke);
        string tag;
        logic [2:0] e;
        for (int i = 0; i < NB; i++) bank_status[i*5 +: 5] = st[i];
        @(negedge clk);
        owned_mask = mask; mode_tstamp = ts; mode_log_all = la;
        mode_no_log = nl; ce_suppress = sp; now_tsc = tsc;
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        owned_mask = ~mask; mode_log_all = ~la; mode_no_log = ~nl; ce_suppress = ~sp;
        for (int i = 0; i < NB; i++) begin
            scan_start = poke && (i == 2);
            @(negedge clk);
            if (mask[i]) begin
                e = exp_out(st[i], la, nl, sp, tag);
                chk(tag, {rec_log, rec_fwd, rec_skip}, e);
                chk("R2", {rec_bank, rec_status}, {IW'(i), st[i]});
                chk("R9", {rec_tsc_vld, rec_tsc}, {ts, ts ? tsc : '0});
            end else begin
                chk("R2", {rec_log, rec_fwd, rec_skip}, 3'b000);
            end
            chk("R11", scan_done, (i == NB - 1));
        end
        scan_start = 1'b0;
        @(negedge clk);
        chk("R11", {scan_done, rec_log, rec_fwd, rec_skip}, 4'b0000);
    endtask

    task automatic t_reset;
        chk("R1", {rec_log, rec_fwd, rec_skip, scan_done}, 4'b0000);
    endtask

    task automatic t_corrected;
        for (int i = 0; i < NB; i++) st[i] = 5'b00001 | 5'(i[0] << 4);
        st[3] = 5'b00000;  // R3 invalid
        run_scan('1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hCAFE_0001, 1'b0);  // R4
    endtask

    task automatic t_uncorrected;
        st[0] = 5'b00011; st[1] = 5'b00111; st[2] = 5'b01011; st[3] = 5'b01111;
        st[4] = 5'b10011; st[5] = 5'b10111; st[6] = 5'b00010; st[7] = 5'b11011;
        run_scan('1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234, 1'b0);  // R6 R7
        run_scan('1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h5678, 1'b0);  // R5
    endtask

    task automatic t_withheld;
        st[0] = 5'b00001; st[1] = 5'b10001; st[2] = 5'b00011; st[3] = 5'b10011;
        st[4] = 5'b10111; st[5] = 5'b10000; st[6] = 5'b11111; st[7] = 5'b00111;
        run_scan('1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h9, 1'b0);  // R8 don't-log
        run_scan('1, 1'b1, 1'b1, 1'b0, 1'b1, 32'hA, 1'b0);  // R8 suppress
    endtask

    task automatic t_mask_and_poke;
        for (int i = 0; i < NB; i++) st[i] = 5'b00001;
        run_scan(8'b1010_0110, 1'b0, 1'b0, 1'b0, 1'b0, 32'hB, 1'b1);  // R2 R10 R11
        run_scan(8'b1000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_corrected();
        t_uncorrected();
        t_withheld();
        t_mask_and_poke();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule